// File: doc/BRIEF.md
# SPI Register Write Port

This block is a slave on a four-wire serial bus that lets a host load a small bank of eight-bit registers. It has no data output: the host can only write. The bus inputs are chip select (active low), bit clock and serial data. They are brought into the system clock domain through synchroniser flops. The block samples the bit-clock rising edges in that domain.

A transaction runs while chip select is low and is built from bytes. The first byte is a 7-bit device address followed by a direction bit. The second byte loads a persistent pointer, which holds an auto-increment flag and a 5-bit register address. Each following byte is a data byte. For each data byte the block emits a one-cycle write strobe together with the register address and the data. The register bank sits outside this block and consumes the strobe. The pointer can either stay on one register or step forward after each data byte.

Top module: `spi_regwr_port`

## Requirements
- R1: Serial data is taken on each rising edge of the bit clock while chip select is low, most significant bit first. Bit-clock edges while chip select is high have no effect.
- R2: The first byte of a transaction must be 0x20, which is device address 0010000 followed by a direction bit of 0. With any other first byte, no strobe is issued until chip select goes high.
- R3: The second byte loads the pointer. Bit 7 is the auto-increment flag, bits 4:0 are the register address, and bits 6:5 are ignored.
- R4: Each complete data byte to an accepted address produces exactly one single-cycle `wr_en` pulse. That pulse carries `wr_addr` equal to the pointer and `wr_data` equal to the byte.
- R5: With the flag at 0, every data byte goes to the same address. With the flag at 1, the address advances by one after every data byte, wrapping from 31 to 0.
- R6: After reset `wr_en`, `wr_addr` and `wr_data` are 0, and the pointer holds flag 1 and address 1.
- R7: Data bytes aimed at address 14 (status, read-only) or at any address not below `NUM_REGS` raise no strobe. The pointer still advances for them.
- R8: Chip select going high at any point discards a partly received byte and clears the bit count. The next transaction starts again with the device-address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_clk | input | 1 | Serial bit clock, asynchronous |
| spi_mosi | input | 1 | Serial data in, asynchronous |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 5 | Register address of the write |
| wr_data | output | 8 | Data of the write |

## Verification
The assertions rely on two properties of the input timing.

- Each bit-clock level lasts at least two system clocks, so the synchronised rising edges of a byte are spread over many cycles. This means two write strobes can never fall on adjacent cycles.
- Chip select only changes while the bit clock is low, so an edge is never sampled in the same cycle that chip select changes.

The stimulus meets both properties: it holds every bit-clock phase for four system clocks and moves chip select only with the bit clock low and quiet.

// File: rtl/spi_regwr_pkg.sv
package spi_regwr_pkg;
  localparam int PTR_ADDR_W = 5;
  localparam int BYTE_W     = 8;
  localparam int INCR_BIT   = 7;

  typedef enum logic [1:0] {
    PH_CHIP = 2'd0,
    PH_PTR  = 2'd1,
    PH_DATA = 2'd2,
    PH_DROP = 2'd3
  } phase_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_in,
  input  logic sclk_in,
  input  logic mosi_in,
  output logic cs_act,
  output logic sclk_rise,
  output logic mosi_s
);
  logic [STAGES-1:0] cs_sr;
  logic [STAGES-1:0] ck_sr;
  logic [STAGES-1:0] md_sr;
  logic              ck_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sr   <= '1;
      ck_sr   <= '0;
      md_sr   <= '0;
      ck_last <= 1'b0;
    end else begin
      cs_sr   <= {cs_sr[STAGES-2:0], cs_n_in};
      ck_sr   <= {ck_sr[STAGES-2:0], sclk_in};
      md_sr   <= {md_sr[STAGES-2:0], mosi_in};
      ck_last <= ck_sr[STAGES-1];
    end
  end

  assign cs_act    = ~cs_sr[STAGES-1];
  assign sclk_rise = ck_sr[STAGES-1] & ~ck_last & cs_act;
  assign mosi_s    = md_sr[STAGES-1];
endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx
  import spi_regwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              mosi_s,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_dat
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      byte_dat <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
          byte_dat <= {shreg, mosi_s};
          byte_vld <= 1'b1;
          bit_cnt  <= '0;
        end else begin
          shreg   <= {shreg[BYTE_W-3:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_txn_ctrl.sv
module spi_txn_ctrl
  import spi_regwr_pkg::*;
#(
  parameter logic [6:0] CHIP_ID     = 7'b0010000,
  parameter int         NUM_REGS    = 24,
  parameter int         STATUS_ADDR = 14,
  parameter bit         HAS_STATUS  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_act,
  input  logic                  byte_vld,
  input  logic [BYTE_W-1:0]     byte_dat,
  output logic                  wr_en,
  output logic [PTR_ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0]     wr_data,
  output phase_t                phase_o,
  output logic                  ptr_incr_o,
  output logic [PTR_ADDR_W-1:0] ptr_addr_o
);
  localparam logic [BYTE_W-1:0] HDR_WRITE = {CHIP_ID, 1'b0};

  phase_t                phase;
  logic                  ptr_incr;
  logic [PTR_ADDR_W-1:0] ptr_addr;
  logic                  addr_ok;
  logic                  is_status;

  generate
    if (HAS_STATUS) begin : g_status
      assign is_status = (int'(ptr_addr) == STATUS_ADDR);
    end else begin : g_nostatus
      assign is_status = 1'b0;
    end
  endgenerate

  assign addr_ok = !is_status && (int'(ptr_addr) < NUM_REGS);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_CHIP;
      ptr_incr <= 1'b1;
      ptr_addr <= PTR_ADDR_W'(1);
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (!cs_act) begin
        phase <= PH_CHIP;
      end else if (byte_vld) begin
        case (phase)
          PH_CHIP: phase <= (byte_dat == HDR_WRITE) ? PH_PTR : PH_DROP;
          PH_PTR: begin
            ptr_incr <= byte_dat[INCR_BIT];
            ptr_addr <= byte_dat[PTR_ADDR_W-1:0];
            phase    <= PH_DATA;
          end
          PH_DATA: begin
            if (addr_ok) begin
              wr_en   <= 1'b1;
              wr_addr <= ptr_addr;
              wr_data <= byte_dat;
            end
            if (ptr_incr) ptr_addr <= ptr_addr + 1'b1;
          end
          default: phase <= PH_DROP;
        endcase
      end
    end
  end

  assign phase_o    = phase;
  assign ptr_incr_o = ptr_incr;
  assign ptr_addr_o = ptr_addr;
endmodule

// File: rtl/spi_regwr_port.sv
module spi_regwr_port
  import spi_regwr_pkg::*;
#(
  parameter logic [6:0] CHIP_ID     = 7'b0010000,
  parameter int         NUM_REGS    = 24,
  parameter int         STATUS_ADDR = 14,
  parameter bit         HAS_STATUS  = 1'b1,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_cs_n,
  input  logic       spi_clk,
  input  logic       spi_mosi,
  output logic       wr_en,
  output logic [4:0] wr_addr,
  output logic [7:0] wr_data
);
  logic                  cs_act;
  logic                  sclk_rise;
  logic                  mosi_s;
  logic                  byte_vld;
  logic [BYTE_W-1:0]     byte_dat;
  phase_t                phase;
  logic                  ptr_incr;
  logic [PTR_ADDR_W-1:0] ptr_addr;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .cs_n_in(spi_cs_n), .sclk_in(spi_clk), .mosi_in(spi_mosi),
    .cs_act(cs_act), .sclk_rise(sclk_rise), .mosi_s(mosi_s)
  );

  spi_byte_rx u_rx (
    .clk(clk), .rst(rst),
    .cs_act(cs_act), .sclk_rise(sclk_rise), .mosi_s(mosi_s),
    .byte_vld(byte_vld), .byte_dat(byte_dat)
  );

  spi_txn_ctrl #(
    .CHIP_ID(CHIP_ID), .NUM_REGS(NUM_REGS),
    .STATUS_ADDR(STATUS_ADDR), .HAS_STATUS(HAS_STATUS)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cs_act(cs_act), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .phase_o(phase), .ptr_incr_o(ptr_incr), .ptr_addr_o(ptr_addr)
  );
endmodule

// File: rtl/spi_regwr_port_chk.sv
module spi_regwr_port_chk
  import spi_regwr_pkg::*;
#(
  parameter int NUM_REGS    = 24,
  parameter int STATUS_ADDR = 14
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cs_act,
  input phase_t                phase,
  input logic                  ptr_incr,
  input logic [PTR_ADDR_W-1:0] ptr_addr,
  input logic                  wr_en,
  input logic [PTR_ADDR_W-1:0] wr_addr
);
  // R6: pointer comes out of reset with increment on, address 1
  a_r6_ptr_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ptr_incr && ptr_addr == PTR_ADDR_W'(1)));

  // R7: no strobe to status or unimplemented addresses
  a_r7_legal_addr: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_addr) != STATUS_ADDR && int'(wr_addr) < NUM_REGS));

  // R4: strobe lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R8: inactive chip select leaves no write behind
  a_r8_cs_abort: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !wr_en);

  // R2: rejected header yields no write
  a_r2_drop_silent: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DROP) |=> !wr_en);

  // R5: pointer relation to the write just made
  a_r5_hold_ptr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ptr_incr) |-> (ptr_addr == wr_addr));
  a_r5_step_ptr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ptr_incr) |-> (ptr_addr == wr_addr + 1'b1));
endmodule

bind spi_regwr_port spi_regwr_port_chk #(
  .NUM_REGS(NUM_REGS), .STATUS_ADDR(STATUS_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .cs_act(cs_act), .phase(phase),
  .ptr_incr(ptr_incr), .ptr_addr(ptr_addr),
  .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/spi_regwr_port_tb.sv
module spi_regwr_port_tb_top;
  localparam int NREG   = 24;
  localparam int STAT   = 14;
  localparam int HALF   = 4;
  localparam int WD_MAX = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_cs_n = 1'b1;
  logic       spi_clk = 1'b0;
  logic       spi_mosi = 1'b0;
  logic       wr_en;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string cur_tag = "R6";

  logic [7:0] tx_q[$];
  logic [4:0] exp_a[$];
  logic [7:0] exp_d[$];
  int  m_incr = 1;
  int  m_addr = 1;

  always #2 clk = ~clk;

  spi_regwr_port #(.NUM_REGS(NREG), .STATUS_ADDR(STAT)) dut_i (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_clk(spi_clk),
    .spi_mosi(spi_mosi), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // compare every strobe against the model's queue
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      if (exp_a.size() == 0) begin
        check(1'b0, cur_tag, "unexpected write addr", int'(wr_addr), 0);
      end else begin
        logic [4:0] ea;
        logic [7:0] ed;
        ea = exp_a.pop_front();
        ed = exp_d.pop_front();
        check(wr_addr == ea, cur_tag, "write addr", int'(wr_addr), int'(ea));
        check(wr_data == ed, cur_tag, "write data", int'(wr_data), int'(ed));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_MAX) begin
      check(1'b0, "watchdog", "cycles", cyc, WD_MAX);
      report();
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      spi_mosi = v[i];
      wait_clks(HALF);
      spi_clk = 1'b1;
      wait_clks(HALF);
      spi_clk = 1'b0;
    end
  endtask

  // behavioural model of a transaction, then drive it on the pins
  task automatic send_txn(input string tag, input int pbits, input logic [7:0] pval);
    bit live = 1'b1;
    cur_tag = tag;
    for (int k = 0; k < tx_q.size(); k++) begin
      if (k == 0) live = (tx_q[k] == 8'h20);
      else if (!live) ;
      else if (k == 1) begin
        m_incr = int'(tx_q[k][7]);
        m_addr = int'(tx_q[k][4:0]);
      end else begin
        if (m_addr != STAT && m_addr < NREG) begin
          exp_a.push_back(5'(m_addr));
          exp_d.push_back(tx_q[k]);
        end
        if (m_incr != 0) m_addr = (m_addr + 1) % 32;
      end
    end
    spi_cs_n = 1'b0;
    wait_clks(HALF);
    for (int k = 0; k < tx_q.size(); k++) send_bits(tx_q[k], 8);
    if (pbits > 0) send_bits(pval, pbits);
    wait_clks(HALF);
    spi_cs_n = 1'b1;
    wait_clks(6 * HALF);
    check(exp_a.size() == 0, tag, "writes still pending", exp_a.size(), 0);
    tx_q.delete();
  endtask

  initial begin
    wait_clks(4);
    rst = 1'b0;
    wait_clks(2);
    // R6: reset state of outputs
    check(wr_en == 1'b0, "R6", "wr_en after reset", int'(wr_en), 0);
    check(wr_addr == 5'd0, "R6", "wr_addr after reset", int'(wr_addr), 0);
    check(wr_data == 8'd0, "R6", "wr_data after reset", int'(wr_data), 0);

    // R4: single write
    tx_q = '{8'h20, 8'h03, 8'hA5};
    send_txn("R4", 0, 8'h00);

    // R1: bit order, MSB first
    tx_q = '{8'h20, 8'h02, 8'h80, 8'h01};
    send_txn("R1", 0, 8'h00);

    // R1: bit-clock toggles with chip select high are ignored
    cur_tag = "R1";
    for (int i = 0; i < 12; i++) begin
      spi_mosi = i[0];
      wait_clks(HALF); spi_clk = 1'b1;
      wait_clks(HALF); spi_clk = 1'b0;
    end
    wait_clks(4 * HALF);
    check(exp_a.size() == 0, "R1", "no write with cs high", exp_a.size(), 0);

    // R5: increment off, same register
    tx_q = '{8'h20, 8'h05, 8'h11, 8'h22, 8'h33};
    send_txn("R5", 0, 8'h00);

    // R5: increment on with wrap 30,31,0
    tx_q = '{8'h20, 8'h9E, 8'h01, 8'h02, 8'h03};
    send_txn("R5", 0, 8'h00);

    // R3: bits 6:5 of pointer ignored
    tx_q = '{8'h20, 8'h63, 8'h5A, 8'h6B};
    send_txn("R3", 0, 8'h00);

    // R7: status address skipped, pointer still advances
    tx_q = '{8'h20, 8'h8C, 8'hC0, 8'hC1, 8'hC2, 8'hC3};
    send_txn("R7", 0, 8'h00);

    // R7: unimplemented addresses dropped, wrap to 0 written
    tx_q = '{8'h20, 8'h9F, 8'hD0, 8'hD1};
    send_txn("R7", 0, 8'h00);
    tx_q = '{8'h20, 8'h19, 8'hE0};
    send_txn("R7", 0, 8'h00);

    // R2: read direction rejected
    tx_q = '{8'h21, 8'h04, 8'h77, 8'h78};
    send_txn("R2", 0, 8'h00);
    // R2: wrong device address rejected
    tx_q = '{8'h22, 8'h04, 8'h79};
    send_txn("R2", 0, 8'h00);
    tx_q = '{8'h20, 8'h04, 8'h7A};
    send_txn("R2", 0, 8'h00);

    // R8: partial data byte discarded
    tx_q = '{8'h20, 8'h06, 8'h3C};
    send_txn("R8", 5, 8'hFF);
    // R8: partial header then a clean transaction
    send_txn("R8", 3, 8'h20);
    tx_q = '{8'h20, 8'h07, 8'h4D};
    send_txn("R8", 0, 8'h00);

    report();
  end
endmodule